// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two table entries from memory, one after the other. The address is cut into three fields: the top ten bits pick an entry in the outer table, the next ten bits pick an entry in an inner table, and the low twelve bits are the byte offset inside a 4 KiB page. The outer table starts at the page frame given by a root base input. The frame held in the chosen outer entry is the start of the inner table. The frame held in the chosen inner entry becomes the upper part of the physical address.

Every table entry is a 32-bit word. Bits 31:12 hold a frame number and bit 0 is the valid flag. If the entry read at either level is invalid, the walk stops and reports a fault together with the level where it stopped. Table reads go out on a request channel with a valid/ready handshake. The read data comes back on a separate response strobe. A result stays on the response port until the consumer accepts it. The walker takes a new request only when it is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: req_ready_o is 1, mem_req_valid_o is 0 and rsp_valid_o is 0.
- R2: The first memory read of a walk uses the address {root frame, 12'b0} + vaddr[31:22]*4.
- R3: The second memory read uses the address {outer entry bits 31:12, 12'b0} + vaddr[21:12]*4.
- R4: A walk with both entries valid responds with rsp_fault_o=0 and rsp_paddr_o = {inner entry bits 31:12, vaddr[11:0]}.
- R5: An outer entry with bit 0 clear ends the walk after exactly one memory read, with rsp_fault_o=1 and rsp_fault_lvl_o=0.
- R6: An inner entry with bit 0 clear ends the walk after two memory reads, with rsp_fault_o=1 and rsp_fault_lvl_o=1.
- R7: While mem_req_ready_i is low, a raised mem_req_valid_o stays high and mem_req_addr_o does not change. Each level issues exactly one accepted read.
- R8: rsp_valid_o and the response fields stay unchanged until rsp_ready_i is high. The walker returns to idle in the cycle after the response is accepted.
- R9: Request inputs that arrive while a walk is in progress are ignored. The result and the read addresses depend only on the request that was accepted.
- R10: The root frame is captured when a request is accepted. Changes to root_base_i during the walk have no effect.
- R11: Entry bits 11:1 are ignored at both levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Walk request strobe |
| req_ready_o | output | 1 | Walker is idle and takes a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| root_base_i | input | 20 | Frame number of the outer table |
| mem_req_valid_o | output | 1 | Table read request |
| mem_req_ready_i | input | 1 | Memory takes the read request |
| mem_req_addr_o | output | 32 | Byte address of the table entry |
| mem_rsp_valid_i | input | 1 | Read data strobe |
| mem_rsp_data_i | input | 32 | Entry read from the table |
| rsp_valid_o | output | 1 | Result available |
| rsp_ready_i | input | 1 | Consumer takes the result |
| rsp_paddr_o | output | 32 | Translated physical address |
| rsp_fault_o | output | 1 | Walk ended on an invalid entry |
| rsp_fault_lvl_o | output | 1 | Level of the fault: 0 outer, 1 inner |

## Verification
The hardest case to reach is a walk that is disturbed on every side at the same time. Memory stalls the request channel and answers late, a second request and a new root frame arrive during the walk, and the consumer holds back the result. The bench memory model alternates its ready signal and waits several cycles before it answers. While the first read is still pending, the bench pulses a different request and changes the root base. It then keeps rsp_ready_i low for several cycles. It checks the logged read addresses, the read count and the held result against values computed from the request that was first accepted. Entries carry junk in bits 11:1, and a corner-index address exercises both indices at their maximum value.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned ENT_SH = 2;  // log2 of entry bytes
  localparam int unsigned FRM_W  = VA_W - OFF_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_OUTER,
    ST_READ_INNER,
    ST_DONE,
    ST_FAULT
  } walk_state_e;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
  import ptw_pkg::*;
#(
  parameter int unsigned AW  = VA_W,
  parameter int unsigned FW  = FRM_W,
  parameter int unsigned IW  = IDX_W,
  parameter int unsigned SH  = ENT_SH
) (
  input  logic [FW-1:0] tbl_frame_i,
  input  logic [IW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned OW = AW - FW;

  logic [AW-1:0] base;
  logic [AW-1:0] disp;

  assign base   = {tbl_frame_i, {OW{1'b0}}};
  assign disp   = AW'({idx_i, {SH{1'b0}}});
  assign addr_o = base + disp;
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
  import ptw_pkg::*;
#(
  parameter int unsigned EW = VA_W,
  parameter int unsigned FW = FRM_W
) (
  input  logic [EW-1:0] entry_i,
  output logic [FW-1:0] frame_o,
  output logic          valid_o
);
  assign frame_o = entry_i[EW-1 -: FW];
  assign valid_o = entry_i[0];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [FRM_W-1:0] root_base_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [VA_W-1:0]  mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [VA_W-1:0]  mem_rsp_data_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [VA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o,
  output logic             rsp_fault_lvl_o
);
  localparam int unsigned HI_LSB = OFF_W + IDX_W;

  walk_state_e      state_q;
  logic             issued_q;
  logic [VA_W-1:0]  vaddr_q;
  logic [FRM_W-1:0] tbl_q;
  logic [VA_W-1:0]  paddr_q;
  logic             lvl_q;

  logic [IDX_W-1:0] idx_sel;
  logic [FRM_W-1:0] ent_frame;
  logic             ent_valid;
  logic             got_rsp;

  // tbl_q holds the root frame first, then the inner table frame
  assign idx_sel = (state_q == ST_READ_INNER) ? vaddr_q[OFF_W +: IDX_W]
                                              : vaddr_q[HI_LSB +: IDX_W];

  ptw_entry_addr u_addr (
    .tbl_frame_i (tbl_q),
    .idx_i       (idx_sel),
    .addr_o      (mem_req_addr_o)
  );

  ptw_entry_decode u_dec (
    .entry_i (mem_rsp_data_i),
    .frame_o (ent_frame),
    .valid_o (ent_valid)
  );

  assign got_rsp = issued_q && mem_rsp_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      vaddr_q  <= '0;
      tbl_q    <= '0;
      paddr_q  <= '0;
      lvl_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          state_q  <= ST_READ_OUTER;
          vaddr_q  <= req_vaddr_i;
          tbl_q    <= root_base_i;
          issued_q <= 1'b0;
          lvl_q    <= 1'b0;
        end
        ST_READ_OUTER, ST_READ_INNER: begin
          if (!issued_q && mem_req_ready_i) issued_q <= 1'b1;
          if (got_rsp) begin
            issued_q <= 1'b0;
            if (!ent_valid) begin
              state_q <= ST_FAULT;
              lvl_q   <= (state_q == ST_READ_INNER);
            end else if (state_q == ST_READ_OUTER) begin
              state_q <= ST_READ_INNER;
              tbl_q   <= ent_frame;
            end else begin
              state_q <= ST_DONE;
              paddr_q <= {ent_frame, vaddr_q[OFF_W-1:0]};
            end
          end
        end
        ST_DONE, ST_FAULT: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_READ_OUTER || state_q == ST_READ_INNER) && !issued_q;
  assign rsp_valid_o     = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign rsp_fault_o     = (state_q == ST_FAULT);
  assign rsp_fault_lvl_o = lvl_q;
  assign rsp_paddr_o     = paddr_q;

  p_memreq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  p_rsp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o)
      && $stable(rsp_fault_o) && $stable(rsp_fault_lvl_o));

  p_idle_after_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ready_i |=> req_ready_o && !rsp_valid_o);

  p_rsp_after_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> $past(mem_rsp_valid_i));

  p_busy_after_take_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o && mem_req_valid_o);

  p_no_overlap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({req_ready_o, mem_req_valid_o, rsp_valid_o}) <= 1);
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WDOG_CYC   = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [19:0] root_base_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [31:0] rsp_paddr_o;
  logic        rsp_fault_o;
  logic        rsp_fault_lvl_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mem [int unsigned];
  int          lat   = 1;
  bit          stall = 1'b0;
  int          nreads = 0;
  logic [31:0] rlog [0:7];

  pt_walker dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model: drives all memory inputs at the falling edge
  initial begin
    bit pend = 1'b0;
    int cnt = 0;
    logic [31:0] pa = '0;
    forever begin
      @(negedge clk_i);
      mem_rsp_valid_i = 1'b0;
      if (pend) begin
        if (cnt <= 1) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = rd(pa);
          pend = 1'b0;
        end else cnt--;
      end
      mem_req_ready_i = stall ? ~mem_req_ready_i : 1'b1;
      if (mem_req_valid_o && mem_req_ready_i && !pend) begin
        pend = 1'b1;
        cnt  = lat;
        pa   = mem_req_addr_o;
        if (nreads < 8) rlog[nreads] = mem_req_addr_o;
        nreads++;
      end
    end
  end

  function automatic logic [31:0] outer_addr(input logic [19:0] root, input logic [31:0] va);
    return {root, 12'h0} + {20'h0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] inner_addr(input logic [31:0] oent, input logic [31:0] va);
    return {oent[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
  endfunction

  // one walk; returns the response seen, checks hold behaviour
  task automatic walk(input logic [31:0] va, input logic [19:0] root, input bit disturb,
                      input int hold, output logic [31:0] pa, output bit flt, output bit lvl);
    int t;
    nreads = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_vaddr_i = va;
    root_base_i = root;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (disturb) begin
      req_valid_i = 1'b1;
      req_vaddr_i = ~va;
      root_base_i = 20'h77777;
      @(negedge clk_i);
      @(negedge clk_i);
      req_valid_i = 1'b0;
      chk(!req_ready_o, "R9 busy during walk", {31'h0, req_ready_o}, 32'h0);
    end
    t = 0;
    while (!rsp_valid_o && t < 200) begin
      @(negedge clk_i);
      t++;
    end
    pa  = rsp_paddr_o;
    flt = rsp_fault_o;
    lvl = rsp_fault_lvl_o;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk_i);
      chk(rsp_valid_o && rsp_paddr_o == pa && rsp_fault_o == flt && rsp_fault_lvl_o == lvl,
          "R8 response held", rsp_paddr_o, pa);
    end
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    chk(req_ready_o && !rsp_valid_o, "R8 idle after accept", {30'h0, req_ready_o, rsp_valid_o}, 32'h2);
  endtask

  task automatic t_reset;
    chk(req_ready_o == 1'b1, "R1 req_ready after reset", {31'h0, req_ready_o}, 32'h1);
    chk(mem_req_valid_o == 1'b0, "R1 no mem read after reset", {31'h0, mem_req_valid_o}, 32'h0);
    chk(rsp_valid_o == 1'b0, "R1 no response after reset", {31'h0, rsp_valid_o}, 32'h0);
  endtask

  task automatic t_basic;  // R2 R3 R4 R11
    logic [31:0] pa; bit f, l;
    logic [31:0] va = 32'h00C0_3ABC;
    lat = 1; stall = 1'b0;
    walk(va, 20'h00010, 1'b0, 0, pa, f, l);
    chk(rlog[0] == outer_addr(20'h00010, va), "R2 outer address", rlog[0], outer_addr(20'h00010, va));
    chk(rlog[1] == inner_addr(32'h0002_0001, va), "R3 inner address", rlog[1], inner_addr(32'h0002_0001, va));
    chk(!f && pa == {20'h12345, va[11:0]}, "R4 R11 physical address", pa, {20'h12345, va[11:0]});
  endtask

  task automatic t_stall;  // R7 with max indices
    logic [31:0] pa; bit f, l;
    logic [31:0] va = 32'hFFFF_F123;
    lat = 3; stall = 1'b1;
    walk(va, 20'h00010, 1'b0, 0, pa, f, l);
    chk(nreads == 2, "R7 one read per level", nreads, 2);
    chk(rlog[0] == 32'h0001_0FFC, "R2 outer address max index", rlog[0], 32'h0001_0FFC);
    chk(rlog[1] == 32'h0003_0FFC, "R3 inner address max index", rlog[1], 32'h0003_0FFC);
    chk(!f && pa == 32'hABCD_E123, "R4 address under stalls", pa, 32'hABCD_E123);
  endtask

  task automatic t_outer_fault;  // R5
    logic [31:0] pa; bit f, l;
    lat = 2; stall = 1'b0;
    walk(32'h0080_0000, 20'h00010, 1'b0, 0, pa, f, l);
    chk(f && !l, "R5 outer fault level 0", {30'h0, f, l}, 32'h2);
    chk(nreads == 1, "R5 single read on outer fault", nreads, 1);
  endtask

  task automatic t_inner_fault;  // R6
    logic [31:0] pa; bit f, l;
    lat = 1; stall = 1'b1;
    walk(32'h00C0_4000, 20'h00010, 1'b0, 0, pa, f, l);
    chk(f && l, "R6 inner fault level 1", {30'h0, f, l}, 32'h3);
    chk(nreads == 2, "R6 two reads on inner fault", nreads, 2);
  endtask

  task automatic t_disturb;  // R8 R9 R10
    logic [31:0] pa; bit f, l;
    logic [31:0] va = 32'h00C0_3ABC;
    lat = 4; stall = 1'b1;
    walk(va, 20'h00010, 1'b1, 5, pa, f, l);
    chk(rlog[0] == outer_addr(20'h00010, va), "R10 root captured at accept", rlog[0], outer_addr(20'h00010, va));
    chk(nreads == 2, "R9 no extra walk", nreads, 2);
    chk(!f && pa == 32'h1234_5ABC, "R9 result from first request", pa, 32'h1234_5ABC);
  endtask

  initial begin
    mem[32'h0001_000C] = 32'h0002_0001;
    mem[32'h0002_000C] = 32'h1234_5FFF;
    mem[32'h0001_0FFC] = 32'h0003_0001;
    mem[32'h0003_0FFC] = 32'hABCD_E001;
    mem[32'h0001_0008] = 32'h0004_0FFE;
    mem[32'h0002_0010] = 32'h5555_5000;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_stall();
    t_outer_fault();
    t_inner_fault();
    t_disturb();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", WDOG_CYC);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule